// File: doc/BRIEF.md
# Partial-Freeze Ring Counter Pattern Generator

This block generates test stimulus for a circuit under test as part of a built-in self-test scheme. A seed vector and a group mask are loaded together. Each mask bit sorts one output bit into one of two groups:

- **Acting bits** (mask bit 1) take part in rotation.
- **Frozen bits** (mask bit 0) keep their seed value for as long as that seed is in use.

On every enabled step, the acting bits pass their values around a short ring made only of the acting positions. Frozen positions are skipped, so they see no transitions. This lowers switching activity in the circuit under test.

A mode bit, loaded with the seed, selects how the value crossing the top of the ring is handled:

- **Plain ring:** the value wraps unchanged.
- **Twisting ring:** the value wraps inverted, as in a Johnson counter.

A controller steps through the patterns for one seed. A start strobe presents the seed as the first pattern. Each later step with enable high presents the next rotated pattern. A count limit, taken at start, sets how many patterns the seed produces. When the limit is reached, a one-cycle done pulse follows and the block holds until the next seed is loaded.

Top module: `pfrc_gen`

## Requirements
- R1: When seed_load is high at a clock edge, the pattern register takes seed_in, and the mask and mode register take mask_in and twist_in. Loading takes priority over start and enable in the same cycle.
- R2: In plain mode (twist_in = 0), each rotation step moves the bit at acting position p to the next higher acting position. The bit at the highest acting position moves to the lowest acting position.
- R3: Frozen bits (mask bit 0) never change between seed loads.
- R4: In twisting mode (twist_in = 1), the rotation is the same as in R2 except that the bit wrapping from the highest to the lowest acting position is inverted. With all bits acting and a width of W, the seed therefore returns after 2·W steps.
- R5: In the cycle after start is accepted on a loaded seed, pat_valid is high and pattern equals the seed.
- R6: A clock with enable low leaves pattern unchanged, with pat_valid low. Each clock with enable high and patterns still owed presents the next rotated pattern, with pat_valid high for that one cycle.
- R7: A seed produces exactly pat_limit patterns, where pat_limit is the value sampled at start. done is high for one cycle, on the first enabled clock after the last pattern. With pat_limit = 0, done follows start directly and no pattern is presented.
- R8: After done, pattern holds its last value and start is ignored until a new seed is loaded.
- R9: With no acting bits, the pattern stays constant. With one acting bit, plain mode keeps that bit constant and twisting mode inverts it on each step.
- R10: An active-low synchronous reset clears the pattern, the mask, the count and the outputs pat_valid and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load seed, mask and mode |
| seed_in | input | WIDTH | Seed vector |
| mask_in | input | WIDTH | Group mask, 1 = acting, 0 = frozen |
| twist_in | input | 1 | Ring mode, 0 = plain, 1 = twisting |
| start | input | 1 | Start strobe for the loaded seed |
| enable | input | 1 | Step enable |
| pat_limit | input | CNT_W | Number of patterns for this seed |
| pat_valid | output | 1 | A new pattern is presented this cycle |
| pattern | output | WIDTH | Pattern vector to the circuit under test |
| done | output | 1 | One-cycle pulse after the last pattern |

## Verification
The bench uses sparse, scattered masks. A design that rotated through frozen positions, or that wrapped to the wrong end of the ring, would then move frozen bits or produce the wrong patterns. Full-width twisting runs longer than 2·W steps, so a missing wrap inversion shows up as a premature return to the seed. Runs with no acting bits and with one acting bit expose a predecessor search that fails to fall back to the bit itself. Irregular enable gaps, a limit of zero, a limit of one and a start strobe after done catch an off-by-one count, a stray pattern or a restart without a reload.

// File: rtl/pfrc_pkg.sv
package pfrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } pfrc_state_e;
endpackage

// File: rtl/pfrc_rotate.sv
// Combinational rotation network: each acting bit takes the value of the
// nearest acting bit below it; the lowest acting bit takes the highest one.
module pfrc_rotate #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] pat_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             twist_i,
    output logic [WIDTH-1:0] pat_o
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        logic [IDX_W-1:0] src;
        logic             wrap;
        logic             found;

        always_comb begin
            src   = IDX_W'(j);
            wrap  = 1'b1;
            found = 1'b0;
            for (int k = 1; k < WIDTH; k++) begin : scan
                int idx;
                idx = (j + WIDTH - k) % WIDTH;
                if (!found && mask_i[idx]) begin
                    found = 1'b1;
                    src   = IDX_W'(idx);
                    wrap  = (idx > j);
                end
            end
            pat_o[j] = mask_i[j] ? (pat_i[src] ^ (twist_i & wrap)) : pat_i[j];
        end
    end
endmodule

// File: rtl/pfrc_ctrl.sv
// Sequencing: arm on load, present seed on start, count enabled steps,
// pulse done after the last pattern, hold until the next load.
module pfrc_ctrl
    import pfrc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic             start,
    input  logic             enable,
    input  logic [CNT_W-1:0] pat_limit,
    output logic             step,
    output logic             pat_valid,
    output logic             done
);
    typedef struct packed {
        pfrc_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             valid;
        logic             done;
    } ctrl_s;

    ctrl_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        step      = 1'b0;
        if (seed_load) begin
            r_d.st  = ST_ARMED;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                ST_ARMED: begin
                    if (start) begin
                        r_d.lim = pat_limit;
                        if (pat_limit == '0) begin
                            r_d.st   = ST_FINISH;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st    = ST_RUN;
                            r_d.cnt   = CNT_W'(1);
                            r_d.valid = 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (enable) begin
                        if (r_q.cnt < r_q.lim) begin
                            step      = 1'b1;
                            r_d.cnt   = r_q.cnt + CNT_W'(1);
                            r_d.valid = 1'b1;
                        end else begin
                            r_d.st   = ST_FINISH;
                            r_d.done = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.lim   <= '0;
            r_q.valid <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pat_valid = r_q.valid;
    assign done      = r_q.done;
endmodule

// File: rtl/pfrc_gen.sv
module pfrc_gen #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_in,
    input  logic [WIDTH-1:0] mask_in,
    input  logic             twist_in,
    input  logic             start,
    input  logic             enable,
    input  logic [CNT_W-1:0] pat_limit,
    output logic             pat_valid,
    output logic [WIDTH-1:0] pattern,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] pat;
        logic [WIDTH-1:0] mask;
        logic             twist;
    } gen_s;

    gen_s             g_d, g_q;
    logic             step;
    logic [WIDTH-1:0] rot_pat;
    logic [WIDTH-1:0] mask_q;
    logic             twist_q;

    pfrc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .start     (start),
        .enable    (enable),
        .pat_limit (pat_limit),
        .step      (step),
        .pat_valid (pat_valid),
        .done      (done)
    );

    pfrc_rotate #(.WIDTH(WIDTH)) u_rot (
        .pat_i   (g_q.pat),
        .mask_i  (g_q.mask),
        .twist_i (g_q.twist),
        .pat_o   (rot_pat)
    );

    always_comb begin
        g_d = g_q;
        if (seed_load) begin
            g_d.pat   = seed_in;
            g_d.mask  = mask_in;
            g_d.twist = twist_in;
        end else if (step) begin
            g_d.pat = rot_pat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign pattern = g_q.pat;
    assign mask_q  = g_q.mask;
    assign twist_q = g_q.twist;
endmodule

// File: rtl/pfrc_gen_chk.sv
module pfrc_gen_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seed_load,
    input logic             pat_valid,
    input logic             done,
    input logic [WIDTH-1:0] pattern,
    input logic [WIDTH-1:0] mask_q,
    input logic             twist_q
);
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> $stable(pattern & ~mask_q)); // R3

    AST_PLAIN_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !twist_q) |=> ($countones(pattern) == $past($countones(pattern)))); // R2

    AST_CHANGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> (pat_valid || $stable(pattern))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && pat_valid)); // R7

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !seed_load) |=> (!pat_valid && $stable(pattern))); // R8
endmodule

bind pfrc_gen pfrc_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .pat_valid (pat_valid),
    .done      (done),
    .pattern   (pattern),
    .mask_q    (mask_q),
    .twist_q   (twist_q)
);

// File: tb/tb_pfrc_gen.sv
`timescale 1ns/100ps
module tb_pfrc_gen;
    localparam int W  = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_load = 1'b0;
    logic [W-1:0]  seed_in = '0;
    logic [W-1:0]  mask_in = '0;
    logic          twist_in = 1'b0;
    logic          start = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] pat_limit = '0;
    logic          pat_valid;
    logic [W-1:0]  pattern;
    logic          done;

    int     n_checks = 0;
    int     n_fails = 0;
    int     done_seen = 0;
    bit     finished = 1'b0;
    string  cur_req = "R2";
    logic [W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    pfrc_gen #(.WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
        .mask_in(mask_in), .twist_in(twist_in), .start(start), .enable(enable),
        .pat_limit(pat_limit), .pat_valid(pat_valid), .pattern(pattern), .done(done)
    );

    function automatic logic [W-1:0] model_step(logic [W-1:0] p, logic [W-1:0] m, logic tw);
        int act[$];
        logic [W-1:0] r;
        r = p;
        for (int i = 0; i < W; i++) if (m[i]) act.push_back(i);
        if (act.size() == 0) return p;
        r[act[0]] = p[act[act.size()-1]] ^ tw;
        for (int i = 1; i < act.size(); i++) r[act[i]] = p[act[i-1]];
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected patterns as the design presents them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pat_valid) begin
                if (exp_q.size() == 0) check({cur_req, " unexpected valid"}, pattern, 'x);
                else check(cur_req, pattern, exp_q.pop_front());
            end
            if (done) begin
                check("R7 done with patterns owed", W'(exp_q.size()), '0);
                done_seen++;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // driver: load, start, push the expected sequence, step with an enable gap
    task automatic run_seed(string req, logic [W-1:0] s, logic [W-1:0] m, logic tw,
                            int lim, int gap);
        logic [W-1:0] p;
        int d0, t;
        cur_req = req;
        seed_in = s; mask_in = m; twist_in = tw; seed_load = 1'b1;
        tick();
        seed_load = 1'b0; start = 1'b1; pat_limit = CW'(lim);
        p = s;
        for (int i = 0; i < lim; i++) begin
            exp_q.push_back(p);
            p = model_step(p, m, tw);
        end
        d0 = done_seen;
        tick();
        start = 1'b0;
        t = 0;
        while (done_seen == d0 && t < 4000) begin
            enable = ((t % gap) == 0);
            tick();
            t++;
        end
        enable = 1'b0;
        check({req, " done seen"}, W'(done_seen - d0), W'(1));
        check({req, " queue drained"}, W'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (3) tick();
        check("R10 pattern", pattern, '0);
        check("R10 valid", W'(pat_valid), '0);
        check("R10 done", W'(done), '0);
        rst_n = 1'b1;
        tick();

        run_seed("R2 plain sparse", 16'hA5C3, 16'h0F0F, 1'b0, 6, 1);
        run_seed("R4 twist sparse", 16'hA5C3, 16'h2491, 1'b1, 10, 3);
        run_seed("R4 twist full", 16'h0000, 16'hFFFF, 1'b1, 34, 2);
        check("R4 full twist after 33 steps", pattern, 16'h0001);
        run_seed("R3 frozen scattered", 16'h5A3C, 16'h8421, 1'b0, 9, 4);
        run_seed("R9 no acting", 16'hBEEF, 16'h0000, 1'b1, 4, 1);
        check("R9 no acting constant", pattern, 16'hBEEF);
        run_seed("R9 one acting plain", 16'h1234, 16'h0100, 1'b0, 3, 1);
        run_seed("R9 one acting twist", 16'h1234, 16'h0100, 1'b1, 4, 1);
        check("R9 one acting twist last", pattern, 16'h1334);
        run_seed("R7 limit zero", 16'hC0DE, 16'h00FF, 1'b0, 0, 1);
        check("R7 limit zero no step", pattern, 16'hC0DE);
        run_seed("R5 limit one", 16'h7E81, 16'hF0F0, 1'b1, 1, 1);

        // R6: enable low holds the pattern
        run_seed("R6 gap", 16'h00F0, 16'h0FF0, 1'b0, 5, 5);
        check("R6 final pattern", pattern, model_step(model_step(model_step(model_step(16'h00F0, 16'h0FF0, 1'b0), 16'h0FF0, 1'b0), 16'h0FF0, 1'b0), 16'h0FF0, 1'b0));

        // R8: start after done is ignored; monitor flags any stray valid
        cur_req = "R8 start after done";
        begin
            logic [W-1:0] held;
            held = pattern;
            start = 1'b1; enable = 1'b1;
            repeat (3) tick();
            start = 1'b0;
            repeat (4) tick();
            enable = 1'b0;
            check("R8 held pattern", pattern, held);
        end

        // R1: load wins over start in the same cycle
        cur_req = "R1 load priority";
        seed_in = 16'h3C3C; mask_in = 16'hFFFF; twist_in = 1'b0;
        seed_load = 1'b1; start = 1'b1; pat_limit = CW'(2);
        tick();
        seed_load = 1'b0; start = 1'b0;
        tick();
        check("R1 loaded seed", pattern, 16'h3C3C);
        check("R1 no valid while loading", W'(pat_valid), '0);
        run_seed("R1 reload", 16'h3C3C, 16'h00FF, 1'b0, 3, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule